// File: doc/BRIEF.md
# Valid-Bit Release Command Ring Consumer

This block is the consuming side of a small circular ring of release commands. Software fills ring slots to hand buffers back to numbered pools. Each slot holds a command byte (the verb) and a pool number. The block looks only at the slot under its consumer index. When it decides that software owns that slot, it decodes the verb, offers the pool number, the buffer count and the per-buffer-pool flag on a ready/valid release interface, and steps the consumer index forward. It takes at most one slot per clock.

Ownership of a slot is chosen by a mode field. In valid-bit mode, software marks a slot by writing bit 7 of the verb with the current phase, and the phase that the block expects flips each time its index wraps. In the two index modes, software instead advances a producer index register. A small register file holds both indices, an interrupt threshold, the mode and two write-one-to-clear status bits: one for ring progress and one for malformed verbs. Slot storage is a register array written through a host port.

Top module: `rcr_consumer`

## Requirements
- R1: After synchronous reset the consumer index and producer index both read 4'b1000 (phase 1, slot 0), the mode reads 2, the threshold and status read 0, and rel_valid, ring_irq and verb_err are low.
- R2: In mode 2 a slot is taken only when its verb bit 7 equals the expected phase. The index registers are 4 bits: bits 2:0 give the slot and bit 3 gives the expected phase. The phase starts at 1 and flips each time the slot index wraps from 7 to 0. A slot holding the other phase is left alone.
- R3: Verb bits 6:4 give the command: 3'b010 releases with one pool number (rel_multi low) and 3'b011 releases with one pool number per buffer (rel_multi high). Verb bits 3:0 give the buffer count and go to rel_count. The slot's pool byte goes to rel_pool. rel_count is always between 1 and 8 while rel_valid is high.
- R4: A verb with any other command, or with a count of 0 or above 8, is consumed without a release. It sets the sticky error (status bit 1 and verb_err), which is cleared by writing 1 to status bit 1.
- R5: While rel_valid is high and rel_ready is low, the release fields hold steady. The consumer index then moves by at most the one slot that filled the output.
- R6: In modes 0 and 1 a slot is taken whenever the producer index differs from the consumer index (all 4 bits), and software writes the producer index at offset 0. In mode 2 the producer index register follows the consumer index, and writes to it are ignored.
- R7: In mode 3 no slot is taken.
- R8: After each consumption the outstanding count is (producer index minus new consumer index) mod 16 in modes 0, 1 and 3, and 0 in mode 2. If it is at most the 3-bit threshold, status bit 0 and ring_irq are set. Writing 1 to status bit 0 clears them, and a set in the same cycle wins.
- R9: Register offsets are producer index 0, consumer index 1 (read-only), threshold 2, mode 3 and status 4. csr_rdata shows the register at csr_addr one clock later, and unmapped offsets read 0.
- R10: A slot written at clock edge k (already owned) appears on rel_valid after edge k+1. With rel_ready high, owned slots are released on consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ent_we | input | 1 | Slot write strobe |
| ent_slot | input | 3 | Slot number written |
| ent_verb | input | 8 | Verb byte written to the slot |
| ent_pool | input | 8 | Pool number written to the slot |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 3 | Register offset for read and write |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Registered read data |
| rel_valid | output | 1 | Release request valid |
| rel_ready | input | 1 | Downstream accepts the release |
| rel_pool | output | 8 | Pool number of the release |
| rel_count | output | 4 | Buffer count, 1 to 8 |
| rel_multi | output | 1 | One pool number per buffer |
| ring_irq | output | 1 | Ring interrupt status |
| verb_err | output | 1 | Sticky malformed-verb flag |

## Verification
A wrong consumer index or phase shows up at the ports within one clock. Either a stale slot is released or a fresh one is never taken, and both show on rel_valid on the next edge and in the consumer index read. The bench keeps its own slot contents, indices, phase, status bits and output register, and compares every output on every clock. So a fault in ownership, decode, backpressure or status logic is caught in the first cycle it shows. Directed sequences drive a full ring wrap with phase reversal, stale-phase slots, long backpressure, each class of malformed verb, the index modes with thresholds on both sides, and the halt mode.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  localparam int VERB_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [1:0] {
    MODE_IDX_UNC = 2'd0,
    MODE_IDX_CAC = 2'd1,
    MODE_VALID   = 2'd2,
    MODE_HALT    = 2'd3
  } rcr_mode_e;

  localparam int REG_PI   = 0;
  localparam int REG_CI   = 1;
  localparam int REG_THR  = 2;
  localparam int REG_CFG  = 3;
  localparam int REG_STAT = 4;

  localparam logic [2:0] CMD_ONE_POOL  = 3'b010;
  localparam logic [2:0] CMD_PER_BUF   = 3'b011;
endpackage

// File: rtl/rcr_slot_store.sv
module rcr_slot_store #(
  parameter int DEPTH = 8,
  parameter int ENT_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [ENT_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [ENT_W-1:0] rdata
);
  logic [ENT_W-1:0] slots_q [DEPTH];

  // Small distributed array; cleared on reset so stale verbs never look owned.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) slots_q[i] <= '0;
    end else if (we) begin
      slots_q[waddr] <= wdata;
    end
  end

  assign rdata = slots_q[raddr];
endmodule

// File: rtl/rcr_verb_decode.sv
module rcr_verb_decode #(
  parameter int MAX_CNT = 8
) (
  input  logic [rcr_pkg::VERB_W-1:0] verb,
  output logic                       legal,
  output logic                       multi,
  output logic [rcr_pkg::CNT_W-1:0]  count
);
  import rcr_pkg::*;
  logic [2:0] cmd;
  logic       cmd_ok;
  logic       cnt_ok;

  always_comb begin
    cmd    = verb[6:4];
    count  = verb[CNT_W-1:0];
    cmd_ok = (cmd == CMD_ONE_POOL) || (cmd == CMD_PER_BUF);
    cnt_ok = (count != '0) && (int'(count) <= MAX_CNT);
    legal  = cmd_ok && cnt_ok;
    multi  = (cmd == CMD_PER_BUF);
  end
endmodule

// File: rtl/rcr_csr.sv
module rcr_csr #(
  parameter int DEPTH  = 8,
  parameter int CSR_AW = 3,
  parameter int CSR_DW = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [CSR_DW-1:0] csr_wdata,
  output logic [CSR_DW-1:0] csr_rdata,
  input  logic              consume,
  input  logic              bad,
  input  logic [PTR_W-1:0]  ci_cur,
  input  logic [PTR_W-1:0]  ci_nx,
  output logic [PTR_W-1:0]  pi_o,
  output rcr_pkg::rcr_mode_e mode_o,
  output logic              irq_o,
  output logic              err_o
);
  import rcr_pkg::*;

  logic [PTR_W-1:0] pi_q;
  rcr_mode_e        mode_q;
  logic [IDX_W-1:0] thr_q;
  logic             irq_q, err_q;
  logic [PTR_W-1:0] fill_after;
  logic             hit_thr;
  logic             wr_pi, wr_thr, wr_cfg, wr_stat;
  logic [CSR_DW-1:0] rd_nx;

  always_comb begin
    wr_pi   = csr_we && (csr_addr == CSR_AW'(REG_PI));
    wr_thr  = csr_we && (csr_addr == CSR_AW'(REG_THR));
    wr_cfg  = csr_we && (csr_addr == CSR_AW'(REG_CFG));
    wr_stat = csr_we && (csr_addr == CSR_AW'(REG_STAT));
    fill_after = (mode_q == MODE_VALID) ? '0 : (pi_q - ci_nx);
    hit_thr = consume && (fill_after <= {1'b0, thr_q});
  end

  always_comb begin
    rd_nx = '0;
    case (csr_addr)
      CSR_AW'(REG_PI):   rd_nx[PTR_W-1:0] = pi_q;
      CSR_AW'(REG_CI):   rd_nx[PTR_W-1:0] = ci_cur;
      CSR_AW'(REG_THR):  rd_nx[IDX_W-1:0] = thr_q;
      CSR_AW'(REG_CFG):  rd_nx[1:0]       = mode_q;
      CSR_AW'(REG_STAT): rd_nx[1:0]       = {err_q, irq_q};
      default:           rd_nx            = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pi_q      <= {1'b1, {IDX_W{1'b0}}};
      mode_q    <= MODE_VALID;
      thr_q     <= '0;
      irq_q     <= 1'b0;
      err_q     <= 1'b0;
      csr_rdata <= '0;
    end else begin
      csr_rdata <= rd_nx;
      if (mode_q == MODE_VALID) pi_q <= ci_nx;
      else if (wr_pi)           pi_q <= csr_wdata[PTR_W-1:0];
      if (wr_cfg) mode_q <= rcr_mode_e'(csr_wdata[1:0]);
      if (wr_thr) thr_q  <= csr_wdata[IDX_W-1:0];
      if (hit_thr)                    irq_q <= 1'b1;
      else if (wr_stat && csr_wdata[0]) irq_q <= 1'b0;
      if (bad)                        err_q <= 1'b1;
      else if (wr_stat && csr_wdata[1]) err_q <= 1'b0;
    end
  end

  assign pi_o   = pi_q;
  assign mode_o = mode_q;
  assign irq_o  = irq_q;
  assign err_o  = err_q;

  // R6: in valid-bit mode the producer register trails the consumer exactly
  assert_pi_mirror_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_VALID) |=> (pi_q == ci_cur))
    else $error("producer index not mirroring consumer");

  // R7: halt mode takes nothing
  assert_halt_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_HALT) |-> !consume)
    else $error("slot taken in halt mode");

  // R8: ring status only rises after a consumption
  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(consume))
    else $error("ring status set without consumption");

  // R4: error only rises after a malformed verb
  assert_err_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> $past(bad))
    else $error("error flag set without malformed verb");
endmodule

// File: rtl/rcr_consumer.sv
module rcr_consumer #(
  parameter int DEPTH   = 8,
  parameter int POOL_W  = 8,
  parameter int MAX_CNT = 8,
  parameter int CSR_AW  = 3,
  parameter int CSR_DW  = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ent_we,
  input  logic [$clog2(DEPTH)-1:0]  ent_slot,
  input  logic [7:0]                ent_verb,
  input  logic [POOL_W-1:0]         ent_pool,
  input  logic                      csr_we,
  input  logic [CSR_AW-1:0]         csr_addr,
  input  logic [CSR_DW-1:0]         csr_wdata,
  output logic [CSR_DW-1:0]         csr_rdata,
  output logic                      rel_valid,
  input  logic                      rel_ready,
  output logic [POOL_W-1:0]         rel_pool,
  output logic [3:0]                rel_count,
  output logic                      rel_multi,
  output logic                      ring_irq,
  output logic                      verb_err
);
  import rcr_pkg::*;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;
  localparam int ENT_W = VERB_W + POOL_W;

  logic [PTR_W-1:0]  ci_q, ci_nx, pi_w;
  rcr_mode_e         mode_w;
  logic [ENT_W-1:0]  slot_rd;
  logic [VERB_W-1:0] slot_verb;
  logic [POOL_W-1:0] slot_pool;
  logic              owned, out_free, take, legal, multi_d;
  logic [CNT_W-1:0]  count_d;

  rcr_slot_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (ent_we),
    .waddr (ent_slot),
    .wdata ({ent_verb, ent_pool}),
    .raddr (ci_q[IDX_W-1:0]),
    .rdata (slot_rd)
  );

  assign slot_verb = slot_rd[ENT_W-1 -: VERB_W];
  assign slot_pool = slot_rd[POOL_W-1:0];

  rcr_verb_decode #(.MAX_CNT(MAX_CNT)) u_dec (
    .verb  (slot_verb),
    .legal (legal),
    .multi (multi_d),
    .count (count_d)
  );

  rcr_csr #(.DEPTH(DEPTH), .CSR_AW(CSR_AW), .CSR_DW(CSR_DW)) u_csr (
    .clk       (clk),
    .rst       (rst),
    .csr_we    (csr_we),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .consume   (take),
    .bad       (take && !legal),
    .ci_cur    (ci_q),
    .ci_nx     (ci_nx),
    .pi_o      (pi_w),
    .mode_o    (mode_w),
    .irq_o     (ring_irq),
    .err_o     (verb_err)
  );

  // Ownership: in-band phase bit or producer/consumer comparison.
  always_comb begin
    case (mode_w)
      MODE_VALID:                 owned = (slot_verb[VERB_W-1] == ci_q[PTR_W-1]);
      MODE_IDX_UNC, MODE_IDX_CAC: owned = (pi_w != ci_q);
      default:                    owned = 1'b0;
    endcase
    out_free = !rel_valid || rel_ready;
    take     = owned && out_free;
    // carry out of the slot bits flips the phase bit on wrap
    ci_nx    = take ? ci_q + PTR_W'(1) : ci_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ci_q      <= {1'b1, {IDX_W{1'b0}}};
      rel_valid <= 1'b0;
      rel_pool  <= '0;
      rel_count <= '0;
      rel_multi <= 1'b0;
    end else begin
      ci_q <= ci_nx;
      if (take && legal) begin
        rel_valid <= 1'b1;
        rel_pool  <= slot_pool;
        rel_count <= count_d;
        rel_multi <= multi_d;
      end else if (rel_ready) begin
        rel_valid <= 1'b0;
      end
    end
  end

  // R5: stalled release holds its contents
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (rel_valid && !rel_ready) |=> (rel_valid && $stable(rel_pool)
                                   && $stable(rel_count) && $stable(rel_multi)))
    else $error("release changed while stalled");

  // R3: only legal counts leave the block
  assert_count_range_R3: assert property (@(posedge clk) disable iff (rst)
    rel_valid |-> (rel_count != '0 && int'(rel_count) <= MAX_CNT))
    else $error("illegal count on release");

  // R10: consumer index steps by at most one slot per clock
  assert_one_step_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ci_q == $past(ci_q) || ci_q == $past(ci_q) + PTR_W'(1)))
    else $error("consumer index jumped");
endmodule

// File: tb/test_rcr_consumer.sv
`timescale 1ns/1ps
module test_rcr_consumer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ent_we = 1'b0;
  logic [2:0]  ent_slot = '0;
  logic [7:0]  ent_verb = '0;
  logic [7:0]  ent_pool = '0;
  logic        csr_we = 1'b0;
  logic [2:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        rel_valid, rel_multi, ring_irq, verb_err;
  logic        rel_ready = 1'b1;
  logic [7:0]  rel_pool;
  logic [3:0]  rel_count;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rcr_consumer i_rcr_consumer (
    .clk(clk), .rst(rst), .ent_we(ent_we), .ent_slot(ent_slot),
    .ent_verb(ent_verb), .ent_pool(ent_pool), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .rel_valid(rel_valid), .rel_ready(rel_ready), .rel_pool(rel_pool),
    .rel_count(rel_count), .rel_multi(rel_multi), .ring_irq(ring_irq),
    .verb_err(verb_err));

  // ---------------- behavioural reference ----------------
  int m_verb [8];
  int m_pool [8];
  int m_ci, m_pi, m_mode, m_thr, m_rpool, m_rcnt, m_rd;
  bit m_rv, m_rmulti, m_irq, m_err;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_verb[i]) begin m_verb[i] = 0; m_pool[i] = 0; end
      m_ci = 8; m_pi = 8; m_mode = 2; m_thr = 0;
      m_rv = 0; m_rpool = 0; m_rcnt = 0; m_rmulti = 0;
      m_irq = 0; m_err = 0; m_rd = 0;
    end else begin
      int idx, v, cmd, cnt, nci, fill, rd;
      bit own, take, good;
      idx = m_ci % 8;
      v = m_verb[idx];
      if (m_mode == 2)     own = (((v >> 7) & 1) == (m_ci / 8));
      else if (m_mode < 2) own = (m_pi != m_ci);
      else                 own = 0;
      take = own && (!m_rv || rel_ready);
      cmd = (v >> 4) & 7;
      cnt = v & 15;
      good = (cmd == 2 || cmd == 3) && cnt >= 1 && cnt <= 8;
      nci = take ? (m_ci + 1) % 16 : m_ci;
      fill = (m_mode == 2) ? 0 : (m_pi - nci + 16) % 16;
      case (int'(csr_addr))
        0: rd = m_pi;
        1: rd = m_ci;
        2: rd = m_thr;
        3: rd = m_mode;
        4: rd = (int'(m_err) << 1) | int'(m_irq);
        default: rd = 0;
      endcase
      m_rd = rd;
      if (take && good) begin
        m_rv = 1; m_rpool = m_pool[idx]; m_rcnt = cnt; m_rmulti = (cmd == 3);
      end else if (rel_ready) m_rv = 0;
      if (take && fill <= m_thr) m_irq = 1;
      else if (csr_we && csr_addr == 4 && csr_wdata[0]) m_irq = 0;
      if (take && !good) m_err = 1;
      else if (csr_we && csr_addr == 4 && csr_wdata[1]) m_err = 0;
      if (m_mode == 2) m_pi = nci;
      else if (csr_we && csr_addr == 0) m_pi = int'(csr_wdata[3:0]);
      if (csr_we && csr_addr == 3) m_mode = int'(csr_wdata[1:0]);
      if (csr_we && csr_addr == 2) m_thr = int'(csr_wdata[2:0]);
      if (ent_we) begin m_verb[ent_slot] = int'(ent_verb); m_pool[ent_slot] = int'(ent_pool); end
      m_ci = nci;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(int'(rel_valid), int'(m_rv), "R10 rel_valid");
      if (m_rv) begin
        chk(int'(rel_pool), m_rpool, "R3 rel_pool");
        chk(int'(rel_count), m_rcnt, "R3 rel_count");
        chk(int'(rel_multi), int'(m_rmulti), "R3 rel_multi");
      end
      chk(int'(ring_irq), int'(m_irq), "R8 ring_irq");
      chk(int'(verb_err), int'(m_err), "R4 verb_err");
      chk(int'(csr_rdata), m_rd, "R9 csr_rdata");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic put(input int slot, input int verb, input int pool);
    ent_we = 1; ent_slot = 3'(slot); ent_verb = 8'(verb); ent_pool = 8'(pool);
    @(negedge clk);
    ent_we = 0;
  endtask

  task automatic wr(input int addr, input int data);
    csr_we = 1; csr_addr = 3'(addr); csr_wdata = 32'(data);
    @(negedge clk);
    csr_we = 0;
  endtask

  task automatic rd(input int addr, input int exp, input string tag);
    csr_addr = 3'(addr);
    @(negedge clk);
    chk(int'(csr_rdata), exp, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst = 0;
    idle(1);
    // R1 reset state
    chk(int'(rel_valid), 0, "R1 rel_valid");
    rd(0, 8, "R1 producer index");
    rd(1, 8, "R1 consumer index");
    rd(3, 2, "R1 mode");
    rd(2, 0, "R1 threshold");
    rd(4, 0, "R1 status");
    rd(7, 0, "R9 unmapped offset");

    // R10 latency and R3 decode, phase 1
    put(0, 8'hA2, 5);
    chk(int'(rel_valid), 0, "R10 not yet released");
    idle(1);
    chk(int'(rel_valid), 1, "R10 released one edge later");
    chk(int'(rel_pool), 5, "R3 pool");
    chk(int'(rel_count), 2, "R3 count");
    chk(int'(rel_multi), 0, "R3 single pool");
    put(1, 8'hB8, 6);
    put(2, 8'hA1, 7);
    idle(3);
    rd(1, 11, "R2 consumer index after three");

    // R2 stale phase ignored
    put(3, 8'h21, 9);
    idle(4);
    chk(int'(rel_valid), 0, "R2 stale slot not released");
    rd(1, 11, "R2 index held on stale phase");

    // R2 wrap: rest of lap with phase 1, then slot 0 with phase 0
    for (int s = 3; s < 8; s++) put(s, 8'hA1, 10 + s);
    put(0, 8'h21, 20);
    idle(3);
    rd(1, 1, "R2 phase flipped after wrap");

    // R5 backpressure
    rel_ready = 0;
    put(1, 8'h23, 30);
    put(2, 8'h34, 31);
    idle(4);
    chk(int'(rel_valid), 1, "R5 held valid");
    chk(int'(rel_pool), 30, "R5 held pool");
    rd(1, 2, "R5 only one slot taken");
    rel_ready = 1;
    idle(3);
    rd(1, 3, "R5 drained after ready");

    // R4 malformed verbs
    put(3, 8'h41, 1);
    idle(3);
    chk(int'(verb_err), 1, "R4 bad command flagged");
    rd(1, 4, "R4 bad slot consumed");
    wr(4, 2);
    rd(4, 1, "R4 error cleared, ring status kept");
    put(4, 8'h20, 1);
    put(5, 8'h29, 1);
    idle(3);
    chk(int'(verb_err), 1, "R4 bad count flagged");
    rd(1, 6, "R4 both bad counts consumed");
    wr(0, 0);
    rd(0, 6, "R6 producer write ignored in valid-bit mode");
    wr(4, 3);
    rd(4, 0, "R8 status cleared");

    // R6 index mode with threshold 1
    wr(3, 0);
    wr(2, 1);
    wr(0, 9);
    idle(4);
    rd(1, 9, "R6 index mode consumed to producer");
    rd(4, 1, "R8 threshold reached");

    // R8 threshold not reached while outstanding stays above it
    wr(4, 1);
    wr(2, 0);
    rel_ready = 0;
    wr(0, 11);
    idle(3);
    rd(4, 0, "R8 no status above threshold");
    rel_ready = 1;
    idle(3);
    rd(4, 1, "R8 status at zero outstanding");

    // R7 halt mode
    wr(4, 3);
    wr(3, 3);
    wr(0, 13);
    idle(4);
    chk(int'(rel_valid), 0, "R7 nothing released");
    rd(1, 11, "R7 index held");
    wr(3, 1);
    idle(4);
    rd(1, 13, "R6 cached index mode resumes");

    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule